// File: doc/BRIEF.md
# Two-Stage Clock Synthesizer

This block divides its input clock by a ratio held in one control word. The ratio is the product of two cascaded stages. The first is a power-of-two prescaler that divides by 2^(N+1). The second is an integer divider that divides by (M+1). The block delivers the result in two forms. The first is a clock-enable pulse, one input cycle wide, once per output period. The second is a square wave that flips on every such pulse, which gives a further divide by two at roughly even duty.

Software or a neighbouring controller loads the control word through a simple write port and reads it back through a read port. One write mode replaces the whole 32-bit word. A second mode replaces only the ratio fields and keeps the spare upper bits. A new ratio is held in a shadow until the running output period completes. This means no shortened or stretched period ever appears on the outputs.

Top module: `ratio_clk_synth`

## Requirements
- R1: `clk_en_o` is high for exactly one cycle per output period, and successive pulses lie 2^(N+1) × (M+1) input cycles apart for the active ratio.
- R2: N is read from control bits [15:12]. N=0 makes the prescaler divide by 2, and N=15 by 65536 (a period of 65536 cycles when M=0).
- R3: M is read from control bits [11:0]. M=0 makes the second stage divide by 1, and M=4095 by 4096 (a period of 8192 cycles when N=0).
- R4: A write with `cfg_we`=1 and `cfg_ratio_only`=0 loads all 32 bits of `cfg_wdata`, and `cfg_rdata` shows the stored word from the cycle after the write edge.
- R5: A write with `cfg_we`=1 and `cfg_ratio_only`=1 replaces bits [15:0] only, and bits [31:16] keep their previous value.
- R6: Bits [31:16] are plain storage: changing them with the ratio fields unchanged leaves the output period unchanged.
- R7: A new ratio takes effect only at the next period boundary: the period running when the write lands completes with the old ratio, and a write landing on the same edge as a boundary applies from the boundary after that.
- R8: `clk_div_o` changes value on exactly the cycles in which `clk_en_o` is high and holds otherwise.
- R9: A synchronous reset clears the control word to 0, clears both counters and both outputs, and loads M=0, N=0, so the first periods after reset are 2 cycles long.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Write strobe for the control word |
| cfg_ratio_only | input | 1 | 1: write bits [15:0] only; 0: write all bits |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Current control word |
| clk_en_o | output | 1 | One-cycle pulse per output period |
| clk_div_o | output | 1 | Square wave that flips on each pulse |

## Verification
A control write and a period boundary can land on the same clock edge. In that case, the shadow load at the boundary must still take the old word. The bench provokes this collision on purpose. It waits for a pulse, counts off one period minus one cycle, and then issues the write so that it lands exactly on the next boundary edge. It then requires the following interval to equal the old period, and only the interval after that to take the new ratio. Writes landing one cycle after a boundary are also judged: the period in flight must finish with the old length.

// File: rtl/csynth_pkg.sv
package csynth_pkg;
   // default geometry of the control word
   localparam int CSYN_CTRL_W = 32;
   localparam int CSYN_M_W    = 12;
   localparam int CSYN_N_W    = 4;

   // write modes selected by cfg_ratio_only
   typedef enum logic {
      WR_WHOLE_WORD = 1'b0,
      WR_RATIO_ONLY = 1'b1
   } csyn_wr_mode_e;
endpackage

// File: rtl/csynth_cfg.sv
module csynth_cfg
   import csynth_pkg::*;
#(
   parameter int CTRL_W = CSYN_CTRL_W,
   parameter int M_W    = CSYN_M_W,
   parameter int N_W    = CSYN_N_W
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_i,
   input  logic              ratio_only_i,
   input  logic [CTRL_W-1:0] wdata_i,
   input  logic              load_i,
   output logic [CTRL_W-1:0] rdata_o,
   output logic [M_W-1:0]    act_m_o,
   output logic [N_W-1:0]    act_n_o
);
   localparam int RATIO_W = M_W + N_W;
   localparam logic [CTRL_W-1:0] LOW_MASK = CTRL_W'({RATIO_W{1'b1}});

   logic [CTRL_W-1:0] word_q;
   logic [M_W-1:0]    m_q;
   logic [N_W-1:0]    n_q;
   csyn_wr_mode_e     mode;

   assign mode = csyn_wr_mode_e'(ratio_only_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         word_q <= '0;
      end else if (we_i) begin
         if (mode == WR_RATIO_ONLY)
            word_q <= (word_q & ~LOW_MASK) | (wdata_i & LOW_MASK);
         else
            word_q <= wdata_i;
      end
   end

   // shadow copy, refreshed only at a period boundary
   always_ff @(posedge clk) begin
      if (rst) begin
         m_q <= '0;
         n_q <= '0;
      end else if (load_i) begin
         m_q <= word_q[M_W-1:0];
         n_q <= word_q[RATIO_W-1:M_W];
      end
   end

   assign rdata_o = word_q;
   assign act_m_o = m_q;
   assign act_n_o = n_q;

   p_upper_kept_r5: assert property (@(posedge clk) disable iff (rst)
      (we_i && ratio_only_i) |=> ((rdata_o & ~LOW_MASK) == ($past(rdata_o) & ~LOW_MASK)))
      else $error("ratio-only write disturbed upper control bits");

   p_hold_ratio_r7: assert property (@(posedge clk) disable iff (rst)
      !load_i |=> (act_m_o == $past(act_m_o) && act_n_o == $past(act_n_o)))
      else $error("active ratio changed away from a period boundary");
endmodule

// File: rtl/csynth_prescale.sv
module csynth_prescale #(
   parameter int N_W = 4
) (
   input  logic           clk,
   input  logic           rst,
   input  logic [N_W-1:0] n_i,
   output logic           tick_o
);
   localparam int PRE_W = 2 ** N_W;

   logic [PRE_W-1:0] cnt_q;
   logic [PRE_W-1:0] lim;

   // 2^(N+1)-1; wraps to all ones when N is at its maximum
   assign lim    = (PRE_W'(2) << n_i) - PRE_W'(1);
   assign tick_o = (cnt_q == lim);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (tick_o)
         cnt_q <= '0;
      else
         cnt_q <= cnt_q + PRE_W'(1);
   end

   p_pre_bound_r2: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= lim)
      else $error("prescaler count beyond its limit");
endmodule

// File: rtl/csynth_intdiv.sv
module csynth_intdiv #(
   parameter int M_W = 12
) (
   input  logic           clk,
   input  logic           rst,
   input  logic           tick_i,
   input  logic [M_W-1:0] m_i,
   output logic           last_o
);
   logic [M_W-1:0] cnt_q;

   assign last_o = tick_i && (cnt_q == m_i);

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (tick_i)
         cnt_q <= last_o ? '0 : cnt_q + M_W'(1);
   end

   p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= m_i)
      else $error("integer stage count beyond M");
endmodule

// File: rtl/ratio_clk_synth.sv
module ratio_clk_synth
   import csynth_pkg::*;
#(
   parameter int CTRL_W     = CSYN_CTRL_W,
   parameter int M_W        = CSYN_M_W,
   parameter int N_W        = CSYN_N_W,
   parameter bit HAS_TOGGLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cfg_we,
   input  logic              cfg_ratio_only,
   input  logic [CTRL_W-1:0] cfg_wdata,
   output logic [CTRL_W-1:0] cfg_rdata,
   output logic              clk_en_o,
   output logic              clk_div_o
);
   localparam int RATIO_W = M_W + N_W;

   if (N_W < 1 || N_W > 5) begin : g_bad_n
      $error("N_W must lie in 1..5");
   end
   if (M_W < 1) begin : g_bad_m
      $error("M_W must be at least 1");
   end
   if (CTRL_W < RATIO_W) begin : g_bad_ctrl
      $error("CTRL_W must hold both ratio fields");
   end

   logic [M_W-1:0] act_m;
   logic [N_W-1:0] act_n;
   logic           tick;
   logic           boundary;
   logic           en_q;

   csynth_cfg #(.CTRL_W(CTRL_W), .M_W(M_W), .N_W(N_W)) u_cfg (
      .clk          (clk),
      .rst          (rst),
      .we_i         (cfg_we),
      .ratio_only_i (cfg_ratio_only),
      .wdata_i      (cfg_wdata),
      .load_i       (boundary),
      .rdata_o      (cfg_rdata),
      .act_m_o      (act_m),
      .act_n_o      (act_n)
   );

   csynth_prescale #(.N_W(N_W)) u_pre (
      .clk    (clk),
      .rst    (rst),
      .n_i    (act_n),
      .tick_o (tick)
   );

   csynth_intdiv #(.M_W(M_W)) u_div (
      .clk    (clk),
      .rst    (rst),
      .tick_i (tick),
      .m_i    (act_m),
      .last_o (boundary)
   );

   always_ff @(posedge clk) begin
      if (rst) en_q <= 1'b0;
      else     en_q <= boundary;
   end
   assign clk_en_o = en_q;

   if (HAS_TOGGLE) begin : g_toggle
      logic div_q;
      always_ff @(posedge clk) begin
         if (rst)           div_q <= 1'b0;
         else if (boundary) div_q <= ~div_q;
      end
      assign clk_div_o = div_q;

      p_toggle_on_pulse_r8: assert property (@(posedge clk) disable iff (rst)
         clk_en_o |-> (clk_div_o != $past(clk_div_o)))
         else $error("square wave missed a flip");
      p_toggle_hold_r8: assert property (@(posedge clk) disable iff (rst)
         !clk_en_o |-> $stable(clk_div_o))
         else $error("square wave flipped without a pulse");
   end else begin : g_no_toggle
      assign clk_div_o = 1'b0;
   end

   p_single_pulse_r1: assert property (@(posedge clk) disable iff (rst)
      clk_en_o |=> !clk_en_o)
      else $error("enable pulse longer than one cycle");
endmodule

// File: tb/tb_ratio_clk_synth.sv
`timescale 1ns/1ps
module tb_ratio_clk_synth;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cfg_we = 1'b0;
   logic        cfg_ratio_only = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic        clk_en_o;
   logic        clk_div_o;

   int    n_run = 0;
   int    n_fail = 0;
   longint cyc = 0;
   bit    done = 1'b0;
   logic  last_div = 1'b0;

   ratio_clk_synth dut (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ratio_only(cfg_ratio_only),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .clk_en_o(clk_en_o), .clk_div_o(clk_div_o)
   );

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic longint exp_period(int n, int m);
      return (longint'(1) << (n + 1)) * longint'(m + 1);
   endfunction

   function automatic logic [31:0] ratio_word(int n, int m);
      return {16'h0000, 4'(n), 12'(m)};
   endfunction

   task automatic chk(bit ok, string req, longint act, longint exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", req, act, exp);
      end
   endtask

   // R8: square wave flips with every pulse and holds otherwise
   always @(negedge clk) begin
      if (rst) begin
         last_div = 1'b0;
      end else if (clk_en_o === 1'b1) begin
         chk(clk_div_o === ~last_div, "R8", longint'(clk_div_o), longint'(~last_div));
         last_div = clk_div_o;
      end else if (clk_div_o !== last_div) begin
         chk(1'b0, "R8", longint'(clk_div_o), longint'(last_div));
      end
   end

   task automatic next_pulse(output longint t);
      do @(negedge clk); while (clk_en_o !== 1'b1);
      t = cyc;
   endtask

   // called at a negedge; the write lands on the following posedge
   task automatic write_cfg(logic [31:0] d, logic ratio_only);
      cfg_wdata      = d;
      cfg_ratio_only = ratio_only;
      cfg_we         = 1'b1;
      @(negedge clk);
      cfg_we         = 1'b0;
   endtask

   task automatic do_reset();
      rst = 1'b1;
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      chk(cfg_rdata == 32'h0, "R9", longint'(cfg_rdata), 0);
      chk(clk_en_o == 1'b0 && clk_div_o == 1'b0, "R9", longint'({clk_en_o, clk_div_o}), 0);
      rst = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         n_run++;
         $display("FAIL watchdog: got %0d expected %0d", cyc, 0);
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      longint a, b, c, t0, p1, p2, cur;
      logic [31:0] w;
      void'($urandom(32'h5eed_c10c));

      // R9: reset state and 2-cycle periods afterwards
      do_reset();
      next_pulse(a); next_pulse(b); next_pulse(c);
      chk(b - a == 2, "R9", b - a, 2);
      chk(c - b == 2, "R9", c - b, 2);

      // R4: whole-word write and read back; R1 period
      w = 32'hA5C3_0000 | ratio_word(2, 5);
      write_cfg(w, 1'b0);
      chk(cfg_rdata == w, "R4", longint'(cfg_rdata), longint'(w));
      next_pulse(p1); next_pulse(p2);
      chk(p2 - p1 == exp_period(2, 5), "R1", p2 - p1, exp_period(2, 5));

      // R6: new upper bits, same ratio, same period
      w = 32'h1234_0000 | ratio_word(2, 5);
      write_cfg(w, 1'b0);
      chk(cfg_rdata == w, "R4", longint'(cfg_rdata), longint'(w));
      next_pulse(p1); next_pulse(p2);
      chk(p2 - p1 == exp_period(2, 5), "R6", p2 - p1, exp_period(2, 5));

      // R5: ratio-only write keeps bits [31:16]
      write_cfg(32'hFFFF_0000 | ratio_word(1, 3), 1'b1);
      chk(cfg_rdata == (32'h1234_0000 | ratio_word(1, 3)), "R5",
          longint'(cfg_rdata), longint'(32'h1234_0000 | ratio_word(1, 3)));
      next_pulse(p1); next_pulse(p2);
      chk(p2 - p1 == exp_period(1, 3), "R1", p2 - p1, exp_period(1, 3));
      cur = exp_period(1, 3);

      // R1/R7: random ratios written one cycle after a boundary
      for (int i = 0; i < 12; i++) begin
         int n = $urandom_range(0, 4);
         int m = $urandom_range(0, 31);
         next_pulse(t0);
         write_cfg((32'($urandom()) & 32'hFFFF_0000) | ratio_word(n, m), 1'b1);
         next_pulse(p1);
         chk(p1 - t0 == cur, "R7", p1 - t0, cur);
         next_pulse(p2);
         chk(p2 - p1 == exp_period(n, m), "R1", p2 - p1, exp_period(n, m));
         cur = exp_period(n, m);
      end

      // R7: write landing on the same edge as a boundary
      write_cfg(ratio_word(1, 2), 1'b1);
      next_pulse(p1); next_pulse(p2);
      cur = exp_period(1, 2);
      chk(p2 - p1 == cur, "R1", p2 - p1, cur);
      next_pulse(t0);
      repeat (int'(cur) - 1) @(negedge clk);
      cfg_wdata = ratio_word(0, 0);
      cfg_ratio_only = 1'b1;
      cfg_we = 1'b1;
      @(negedge clk);
      cfg_we = 1'b0;
      next_pulse(p1);
      chk(p1 - t0 == 2 * cur, "R7", p1 - t0, 2 * cur);
      next_pulse(p2);
      chk(p2 - p1 == 2, "R7", p2 - p1, 2);

      // R3: largest M with N=0
      do_reset();
      write_cfg(ratio_word(0, 4095), 1'b1);
      next_pulse(p1); next_pulse(p2);
      chk(p2 - p1 == exp_period(0, 4095), "R3", p2 - p1, exp_period(0, 4095));

      // R2: largest N with M=0
      write_cfg(ratio_word(15, 0), 1'b1);
      next_pulse(p1); next_pulse(p2);
      chk(p2 - p1 == exp_period(15, 0), "R2", p2 - p1, exp_period(15, 0));

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule